// File: doc/BRIEF.md
# Busy-Flag Serial Converter Output Emulator

This block stands in for the digital side of an 18-bit converter. That converter signals the end of each conversion by driving its serial output low, and it then shifts its result out on the falling edges of the serial clock. A host controller under test drives the convert, select, serial clock and turbo lines. The block answers on an output-enable and data pair, which together model a three-state pin: `sdoEn` low means high impedance, and `sdoData` is then held at 0.

All host lines are registered once into the block clock domain. Edges of convert and of the serial clock are detected on the registered copies. A conversion lasts `CONV_CYCLES` clocks. The returned sample is taken when the conversion starts. Its source is chosen by `useCounter`: either a value loaded through `loadEn`/`loadValue`, or a sequence counter that advances once for every conversion started since reset.

Top module: `adcemu_top`

## Requirements
- R1: While reset is asserted, and right after it is released with the host lines unchanged, the output is high impedance (`sdoEn`=0, `sdoData`=0).
- R2: With no conversion or readback in progress, the output is driven low (`sdoEn`=1, `sdoData`=0) when both select and convert are low, and is high impedance otherwise. Whenever `sdoEn` is 0, `sdoData` is 0.
- R3: A rising convert with select high and turbo low starts a conversion. The output stays high impedance until exactly `CONV_CYCLES`+2 clocks after the convert line rises at the port.
- R4: A rising convert while turbo is high starts nothing: no busy flag appears, no data is read out, and the sequence counter does not advance.
- R5: A rising convert while select is low starts nothing. The output keeps following the idle rule of R2.
- R6: At the end of the conversion the output is driven low as the busy-done flag. Falling serial clock edges 1 to 18 then present sample bits 17 down to 0, MSB first.
- R7: The 19th falling serial clock edge returns the output to high impedance.
- R8: Select going high during the busy flag or the readback returns the output to high impedance. Later serial clock edges have no effect.
- R9: If select is still high at or after conversion cycle `SEL_SETTLE`, the busy flag is suppressed. The output stays high impedance and serial clock edges have no effect.
- R10: Convert falling during a conversion or a readback abandons it. The output then follows the idle rule of R2.
- R11: With `useCounter`=1 the sample equals the number of conversions started since reset, counted before the current one. With `useCounter`=0 it equals the last value loaded with `loadEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cnvIn | input | 1 | Convert line from the host |
| selIn | input | 1 | Select / data-in line from the host |
| sckIn | input | 1 | Serial clock from the host |
| turboIn | input | 1 | Turbo line; high blocks this mode |
| useCounter | input | 1 | 1: sample from sequence counter, 0: from loaded register |
| loadEn | input | 1 | Load strobe for the sample register |
| loadValue | input | 18 | Value for the sample register |
| sdoEn | output | 1 | Output driven (1) or high impedance (0) |
| sdoData | output | 1 | Output level when driven |

## Verification
The hardest state to reach is a busy flag that is suppressed because select was released too late. Select must still be high past cycle `SEL_SETTLE` of a running conversion, yet convert must stay high throughout. The bench holds select high well past that cycle in a directed case, then confirms that the output never leaves high impedance, even under serial clock edges. The abort cases are also hard to reach: convert is dropped part-way through a conversion, and part-way through a readback of an all-ones sample. There the output has to fall back to the idle low level rather than a data bit.

// File: rtl/adcemu_pkg.sv
`timescale 1ns/1ps
package adcemu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_BUSY  = 2'd2,
    ST_SHIFT = 2'd3
  } emuState_e;

  typedef struct packed {
    logic capture;
    logic shift;
  } dpStrobe_t;
endpackage

// File: rtl/adcemu_dp.sv
`timescale 1ns/1ps
module adcemu_dp
  import adcemu_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              useCounter,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadValue,
  output logic              msb
);
  logic [DATA_W-1:0] sampleReg;
  logic [DATA_W-1:0] seqCnt;
  logic [DATA_W-1:0] shiftReg;

  // Loadable sample source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleReg <= '0;
    else if (loadEn) sampleReg <= loadValue;
  end

  // Capture at conversion start, then move left one bit per shift strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCnt   <= '0;
      shiftReg <= '0;
    end else if (strobe.capture) begin
      shiftReg <= useCounter ? seqCnt : sampleReg;
      seqCnt   <= seqCnt + DATA_W'(1);
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign msb = shiftReg[DATA_W-1];
endmodule

// File: rtl/adcemu_ctrl.sv
`timescale 1ns/1ps
module adcemu_ctrl
  import adcemu_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 20,
  parameter int SEL_SETTLE  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cnvQ,
  input  logic      selQ,
  input  logic      sckFall,
  input  logic      turboQ,
  output dpStrobe_t strobe,
  output emuState_e stateQ,
  output logic      sdoEn,
  output logic      useShift
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] DONE_C   = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SEL_SETTLE);
  localparam logic [BIT_W-1:0] LAST_C   = BIT_W'(DATA_W);

  logic             cnvPrev;
  logic [CNT_W-1:0] convCnt;
  logic [BIT_W-1:0] fallCnt;
  logic             selOk;
  logic             cnvRise;
  logic             lateSel;
  logic             keepRead;

  assign cnvRise  = cnvQ & ~cnvPrev;
  assign lateSel  = (convCnt >= SETTLE_C) & selQ;
  assign keepRead = cnvQ & ~selQ;

  always_comb begin
    strobe.capture = (stateQ == ST_IDLE) && cnvRise && selQ && !turboQ;
    strobe.shift   = (stateQ == ST_SHIFT) && keepRead && sckFall && (fallCnt != LAST_C);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cnvPrev <= 1'b0;
      convCnt <= '0;
      fallCnt <= '0;
      selOk   <= 1'b0;
    end else begin
      cnvPrev <= cnvQ;
      case (stateQ)
        ST_IDLE: begin
          if (strobe.capture) begin
            stateQ  <= ST_CONV;
            convCnt <= '0;
            selOk   <= 1'b1;
          end
        end
        ST_CONV: begin
          if (!cnvQ) begin
            stateQ <= ST_IDLE;
          end else begin
            selOk <= selOk & ~lateSel;
            if (convCnt == DONE_C) begin
              stateQ <= (selOk && !lateSel) ? ST_BUSY : ST_IDLE;
            end else begin
              convCnt <= convCnt + CNT_W'(1);
            end
          end
        end
        ST_BUSY: begin
          if (!keepRead) begin
            stateQ <= ST_IDLE;
          end else if (sckFall) begin
            stateQ  <= ST_SHIFT;
            fallCnt <= BIT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (!keepRead) begin
            stateQ <= ST_IDLE;
          end else if (sckFall) begin
            if (fallCnt == LAST_C) stateQ <= ST_IDLE;
            else fallCnt <= fallCnt + BIT_W'(1);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (stateQ)
      ST_IDLE:  sdoEn = !cnvQ && !selQ;
      ST_BUSY:  sdoEn = 1'b1;
      ST_SHIFT: sdoEn = 1'b1;
      default:  sdoEn = 1'b0;
    endcase
    useShift = (stateQ == ST_SHIFT);
  end
endmodule

// File: rtl/adcemu_top.sv
`timescale 1ns/1ps
module adcemu_top
  import adcemu_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 20,
  parameter int SEL_SETTLE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              selIn,
  input  logic              sckIn,
  input  logic              turboIn,
  input  logic              useCounter,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadValue,
  output logic              sdoEn,
  output logic              sdoData
);
  logic      cnvQ;
  logic      selQ;
  logic      sckQ;
  logic      sckPrev;
  logic      turboQ;
  logic      sckFall;
  logic      useShift;
  logic      msb;
  dpStrobe_t strobe;
  emuState_e ctrlState;

  // Single register stage on the host lines; select idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvQ    <= 1'b0;
      selQ    <= 1'b1;
      sckQ    <= 1'b0;
      sckPrev <= 1'b0;
      turboQ  <= 1'b0;
    end else begin
      cnvQ    <= cnvIn;
      selQ    <= selIn;
      sckQ    <= sckIn;
      sckPrev <= sckQ;
      turboQ  <= turboIn;
    end
  end

  assign sckFall = sckPrev & ~sckQ;

  adcemu_ctrl #(
    .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .SEL_SETTLE(SEL_SETTLE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cnvQ(cnvQ), .selQ(selQ), .sckFall(sckFall),
    .turboQ(turboQ), .strobe(strobe), .stateQ(ctrlState), .sdoEn(sdoEn),
    .useShift(useShift)
  );

  adcemu_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .useCounter(useCounter),
    .loadEn(loadEn), .loadValue(loadValue), .msb(msb)
  );

  assign sdoData = sdoEn & useShift & msb;
endmodule

// File: rtl/adcemu_chk.sv
`timescale 1ns/1ps
module adcemu_chk
  import adcemu_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sdoEn,
  input logic      sdoData,
  input emuState_e stateQ,
  input logic      cnvQ,
  input logic      selQ,
  input logic      turboQ
);
  p_hiz_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdoData);

  p_conv_hiz_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONV) |-> !sdoEn);

  p_no_turbo_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONV && $past(stateQ) == ST_IDLE) |-> ($past(selQ) && !$past(turboQ)));

  p_busy_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BUSY) |-> (sdoEn && !sdoData));

  p_sel_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_BUSY || stateQ == ST_SHIFT) && selQ) |=> (stateQ == ST_IDLE));

  p_cnv_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && !cnvQ) |=> (stateQ == ST_IDLE));
endmodule

bind adcemu_top adcemu_chk chk_i (
  .clk(clk), .rstN(rstN), .sdoEn(sdoEn), .sdoData(sdoData),
  .stateQ(ctrlState), .cnvQ(cnvQ), .selQ(selQ), .turboQ(turboQ)
);

// File: tb/adcemu_top_tb_top.sv
`timescale 1ns/1ps
module adcemu_top_tb_top;
  localparam int W      = 18;
  localparam int CONV   = 20;
  localparam int SETTLE = 8;
  localparam logic [1:0] HIZ = 2'b00;
  localparam logic [1:0] LOW = 2'b10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cnv, sel, sck, turbo, useCounter, loadEn;
  logic [W-1:0] loadValue;
  logic sdoEn, sdoData;

  int nChecks = 0;
  int nFails  = 0;
  int expCount = 0;
  logic [W-1:0] loaded = '0;
  bit finished = 1'b0;

  adcemu_top #(.DATA_W(W), .CONV_CYCLES(CONV), .SEL_SETTLE(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .cnvIn(cnv), .selIn(sel), .sckIn(sck),
    .turboIn(turbo), .useCounter(useCounter), .loadEn(loadEn),
    .loadValue(loadValue), .sdoEn(sdoEn), .sdoData(sdoData)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [1:0] exp, input string tag);
    nChecks++;
    if ({sdoEn, sdoData} !== exp) begin
      nFails++;
      $display("FAIL %s: got {en,data}=%b expected %b", tag, {sdoEn, sdoData}, exp);
    end
  endtask

  function automatic logic [1:0] bitState(input logic [W-1:0] v, input int n);
    return {1'b1, v[W-n]};
  endfunction

  function automatic logic [W-1:0] nextSample(input logic ctr);
    return ctr ? W'(expCount) : loaded;
  endfunction

  task automatic sckFall();
    sck = 1'b1; tick(3);
    sck = 1'b0; tick(3);
  endtask

  task automatic loadSample(input logic [W-1:0] v);
    loadEn = 1'b1; loadValue = v; tick(1);
    loadEn = 1'b0; loaded = v; tick(1);
  endtask

  // One conversion with readback; assumes sel=1, cnv=0 settled on entry
  task automatic convert(input int nFalls, input bit stopBySel);
    logic [W-1:0] expv;
    expv = nextSample(useCounter);
    expCount++;
    cnv = 1'b1; tick(3);
    sel = 1'b0; tick(CONV - 2);
    check(HIZ, "R3 hiZ on last conversion cycle");
    tick(1);
    check(LOW, "R6 busy flag low");
    for (int n = 1; n <= nFalls; n++) begin
      sckFall();
      if (n <= W) check(bitState(expv, n), "R6/R11 data bit");
      else check(HIZ, "R7 release on 19th fall");
    end
    if (stopBySel && nFalls <= W) begin
      sel = 1'b1; tick(3);
      check(HIZ, "R8 select high releases");
      sckFall();
      check(HIZ, "R8 later fall ignored");
    end
    sel = 1'b1; cnv = 1'b0; tick(3);
    check(HIZ, "R2 idle with select high");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    rstN = 1'b0; cnv = 1'b0; sel = 1'b0; sck = 1'b0; turbo = 1'b0;
    useCounter = 1'b0; loadEn = 1'b0; loadValue = '0;
    tick(3);
    check(HIZ, "R1 hiZ in reset");
    rstN = 1'b1;
    #0;
    check(HIZ, "R1 hiZ at reset release");
    tick(2);
    check(LOW, "R2 driven low, select and convert low");
    sel = 1'b1; tick(2);
    check(HIZ, "R2 hiZ with select high");

    // R5: convert rises with select low
    sel = 1'b0; tick(2);
    cnv = 1'b1; tick(CONV + 5);
    check(HIZ, "R5 no conversion, convert high");
    cnv = 1'b0; tick(2);
    check(LOW, "R5 back to idle low");
    sel = 1'b1; tick(3);

    // R6/R7/R11 loaded register, full readback
    loadSample(18'h2A5C3);
    convert(19, 1'b0);

    // R11 counter mode
    useCounter = 1'b1;
    convert(19, 1'b0);
    useCounter = 1'b0;

    // R4 turbo blocks the mode
    turbo = 1'b1; tick(2);
    cnv = 1'b1; tick(3);
    sel = 1'b0; tick(CONV + 3);
    check(HIZ, "R4 no busy flag with turbo");
    sckFall();
    check(HIZ, "R4 no readback with turbo");
    sel = 1'b1; cnv = 1'b0; turbo = 1'b0; tick(3);

    // R9 select released too late
    cnv = 1'b1; tick(SETTLE + 6);
    sel = 1'b0; tick(CONV);
    expCount++;
    check(HIZ, "R9 busy flag suppressed");
    sckFall();
    check(HIZ, "R9 fall ignored after suppression");
    sel = 1'b1; cnv = 1'b0; tick(3);

    // R10 abort during conversion
    cnv = 1'b1; tick(3);
    sel = 1'b0; tick(5);
    expCount++;
    cnv = 1'b0; tick(3);
    check(LOW, "R10 conversion abort follows idle rule");
    tick(CONV + 3);
    check(LOW, "R10 no busy after abort");
    sel = 1'b1; tick(3);

    // R10 abort during readback of all ones
    loadSample('1);
    cnv = 1'b1; tick(3);
    sel = 1'b0; tick(CONV - 1);
    expCount++;
    check(LOW, "R6 busy flag before abort");
    for (int n = 1; n <= 5; n++) sckFall();
    check(2'b11, "R6 fifth bit of all ones");
    cnv = 1'b0; tick(3);
    check(LOW, "R10 readback abort follows idle rule");
    sckFall();
    check(LOW, "R10 fall ignored after abort");
    sel = 1'b1; tick(3);

    // R11 counter mode after aborted and suppressed conversions
    useCounter = 1'b1;
    convert(W, 1'b1);

    // Constrained random transactions
    for (int i = 0; i < 30; i++) begin
      useCounter = 1'($urandom % 2);
      if (!useCounter) loadSample(W'($urandom));
      convert(int'($urandom % 20), bit'($urandom % 2));
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule